// File: doc/BRIEF.md
# Four-Channel Time-Slotted PCM Serial Port

This block carries 8-bit PCM codes for four voice channels over one shared transmit serial line and one shared receive serial line, all timed by a single master bit clock. Each channel has its own frame sync input. A rising edge on a channel's sync opens that channel's transmit slot, and the channel's code is shifted out MSB first during that slot. Outside every active slot the transmit line is released, so `tx_oe` is low and `tx_data` is held at 0. A pad wrapper can turn this pair into a tri-state pin.

The receive side follows the transmit slots. For each channel, the receive sign bit is sampled on a falling clock edge that sits a programmable number of clock periods after the period that carries the channel's transmit sign bit. The next seven bits are sampled on the seven falling edges after that. The assembled code is posted on a per-channel parallel output together with a one-cycle valid strobe.

A build parameter selects one of two timing variants. In the delayed variant, the first transmit bit appears one clock period after the sync is seen high. In the immediate variant, it appears in the same period as the sync. A sync edge that lands inside a slot that is still running is reported and discarded. A channel in standby neither drives the line nor accepts receive data.

Top module: `pcm_quad_port`

## Requirements
- R1: While `rst` is high and in the first period after it falls, `tx_oe`, `tx_data`, `rx_valid` and `sync_err` are 0 and every `rx_code` lane is 0.
- R2: With `DELAYED`=1, let the sync of a channel first be high in period n, where a period runs from one rising clock edge to the next. The channel's code then drives `tx_data` bit 7 first, bit 0 last, during periods n+1 to n+8, with `tx_oe` high.
- R3: With `DELAYED`=0, the same code drives `tx_data` during periods n to n+7, bit 7 first.
- R4: `tx_oe` is high only during an active slot of some channel, and `tx_data` is 0 whenever `tx_oe` is low. At most one channel drives at a time, provided that slots do not overlap.
- R5: Changing `tx_code` after the rising clock edge that ends period n has no effect on the slot that is running.
- R6: Let S be the period that carries a channel's transmit bit 7, and let D be the value of `rx_delay` at slot start. Bit 7 of the receive code is sampled from `rx_data` on the falling edge inside period S+D, so D=0 gives half a period. Bits 6 to 0 are sampled on the next seven falling edges.
- R7: The channel's `rx_valid` bit is high for exactly period S+D+8. The new code appears on its `rx_code` lane in that same period.
- R8: `rx_code` lanes change only at the end of a receive capture window. `rx_data` outside the windows has no effect.
- R9: A sync rising edge while the channel's slot is still shifting raises that channel's `sync_err` for one period, in the period after the edge is seen, and is otherwise ignored. In the delayed variant, the last bit period counts as free. In the immediate variant, no bit period counts as free.
- R10: With the channel's `standby` bit high, a sync edge starts no slot and raises no error. `tx_oe` stays low for that channel, and its `rx_code` lane and `rx_valid` bit do not change.
- R11: A sync is recognised on its rising edge only. A pulse held high for several periods opens exactly one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fs | input | NCH | Per-channel transmit frame sync |
| standby | input | NCH | Per-channel standby; a set bit silences the channel |
| rx_delay | input | DLY_W | Receive sampling offset in clock periods |
| tx_code | input | NCH x 8 | Parallel transmit code per channel |
| rx_data | input | 1 | Receive serial data, sampled on falling edges |
| tx_data | output | 1 | Transmit serial data, changes on rising edges |
| tx_oe | output | 1 | High while some channel owns the transmit line |
| rx_code | output | NCH x 8 | Last received code per channel |
| rx_valid | output | NCH | One-period strobe for a newly received code |
| sync_err | output | NCH | One-period flag for a sync that arrived during a running slot |

## Verification
For a channel whose sync is first high in period n, the transmit bits are due in periods n+1 to n+8 in the delayed build and in periods n to n+7 in the immediate build. `rx_valid` and the new `rx_code` are due in period S+D+8, and a collision flag is due one period after the offending sync period. The bench drives inputs 1 ns after each rising edge and samples every output 3 ns after the edge, before the falling edge. Its model counts periods from the frame start and compares every output in every period against these due times. A delayed build and an immediate build run side by side on the same stimulus.

// File: rtl/pcm_port_pkg.sv
`timescale 1ns/1ps
package pcm_port_pkg;

    localparam int CODE_W = 8;
    localparam int BIT_W  = $clog2(CODE_W);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [BIT_W-1:0]  bit_idx_t;

    // transmit shifter state of one channel
    typedef struct packed {
        logic     busy;
        bit_idx_t idx;
        code_t    sh;
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_WAIT  = 2'd1,
        RX_SHIFT = 2'd2
    } rx_phase_t;

    // bit index held in the shifter right after the start edge
    function automatic bit_idx_t start_idx(input bit delayed);
        return delayed ? bit_idx_t'(CODE_W-1) : bit_idx_t'(CODE_W-2);
    endfunction

    // immediate variant has already shown the MSB during the sync period
    function automatic code_t start_load(input bit delayed, input code_t c);
        return delayed ? c : {c[CODE_W-2:0], 1'b0};
    endfunction

endpackage

// File: rtl/pcm_rx_sampler.sv
`timescale 1ns/1ps
module pcm_rx_sampler (
    input  logic clk,
    input  logic rst,
    input  logic rx_data,
    output logic rx_bit
);

    // receive line is taken on the falling edge of the bit clock
    always_ff @(negedge clk) begin
        if (rst) rx_bit <= 1'b0;
        else     rx_bit <= rx_data;
    end

endmodule

// File: rtl/pcm_tx_lane.sv
`timescale 1ns/1ps
module pcm_tx_lane
    import pcm_port_pkg::*;
#(
    parameter bit DELAYED = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  fs,
    input  logic  standby,
    input  code_t code,
    output logic  accept,
    output logic  drive,
    output logic  line_bit,
    output logic  err
);

    logic      fs_q;
    tx_state_t st;
    logic      rise;
    logic      collide;

    assign rise    = fs & ~fs_q;
    assign collide = st.busy & (DELAYED ? (st.idx != '0) : 1'b1);
    assign accept  = rise & ~collide & ~standby;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q <= 1'b0;
            st   <= '0;
            err  <= 1'b0;
        end else begin
            fs_q <= fs;
            err  <= rise & collide;
            if (accept) begin
                st.busy <= 1'b1;
                st.idx  <= start_idx(DELAYED);
                st.sh   <= start_load(DELAYED, code);
            end else if (st.busy) begin
                if (st.idx == '0) st.busy <= 1'b0;
                else              st.idx  <= st.idx - 1'b1;
                st.sh <= {st.sh[CODE_W-2:0], 1'b0};
            end
        end
    end

    generate
        if (DELAYED) begin : g_late
            assign drive    = st.busy & ~standby;
            assign line_bit = st.sh[CODE_W-1];
        end else begin : g_early
            assign drive    = (st.busy & ~standby) | accept;
            assign line_bit = st.busy ? st.sh[CODE_W-1] : code[CODE_W-1];
        end
    endgenerate

    // R10
    stby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        standby |-> !drive);

    // R9
    keep_run_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && collide && st.idx != '0) |=>
            (st.busy && st.idx == bit_idx_t'($past(st.idx) - 1'b1)));

endmodule

// File: rtl/pcm_rx_lane.sv
`timescale 1ns/1ps
module pcm_rx_lane
    import pcm_port_pkg::*;
#(
    parameter bit DELAYED = 1'b1,
    parameter int DLY_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             standby,
    input  logic [DLY_W-1:0] delay,
    input  logic             rx_bit,
    output code_t            code_out,
    output logic             valid
);

    localparam int CNT_W = DLY_W + 1;

    logic [CNT_W-1:0] first;
    logic [CNT_W-1:0] wcnt;
    bit_idx_t         left;
    code_t            sh;
    code_t            nxt;
    rx_phase_t        phase;

    // edges from the start edge to the first capture edge
    assign first = DELAYED ? (CNT_W'(delay) + CNT_W'(1)) : CNT_W'(delay);
    assign nxt   = {sh[CODE_W-2:0], rx_bit};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= RX_IDLE;
            wcnt     <= '0;
            left     <= '0;
            sh       <= '0;
            code_out <= '0;
            valid    <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (arm) begin
                if (first == '0) begin
                    sh    <= nxt;
                    left  <= bit_idx_t'(CODE_W-1);
                    phase <= RX_SHIFT;
                end else begin
                    wcnt  <= first - 1'b1;
                    phase <= RX_WAIT;
                end
            end else begin
                unique case (phase)
                    RX_WAIT: begin
                        if (wcnt == '0) begin
                            sh    <= nxt;
                            left  <= bit_idx_t'(CODE_W-1);
                            phase <= RX_SHIFT;
                        end else begin
                            wcnt <= wcnt - 1'b1;
                        end
                    end
                    RX_SHIFT: begin
                        sh <= nxt;
                        if (left == bit_idx_t'(1)) begin
                            phase <= RX_IDLE;
                            if (!standby) begin
                                code_out <= nxt;
                                valid    <= 1'b1;
                            end
                        end else begin
                            left <= left - 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7
    valid_once_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R10
    stby_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!arm && standby && phase == RX_SHIFT && left == bit_idx_t'(1)) |=>
            (!valid && $stable(code_out)));

endmodule

// File: rtl/pcm_quad_port.sv
`timescale 1ns/1ps
module pcm_quad_port
    import pcm_port_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int DLY_W   = 8,
    parameter bit DELAYED = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NCH-1:0]             fs,
    input  logic [NCH-1:0]             standby,
    input  logic [DLY_W-1:0]           rx_delay,
    input  logic [NCH-1:0][CODE_W-1:0] tx_code,
    input  logic                       rx_data,
    output logic                       tx_data,
    output logic                       tx_oe,
    output logic [NCH-1:0][CODE_W-1:0] rx_code,
    output logic [NCH-1:0]             rx_valid,
    output logic [NCH-1:0]             sync_err
);

    logic [NCH-1:0] drive_v;
    logic [NCH-1:0] bit_v;
    logic [NCH-1:0] arm_v;
    logic           rx_bit;

    pcm_rx_sampler u_samp (
        .clk    (clk),
        .rst    (rst),
        .rx_data(rx_data),
        .rx_bit (rx_bit)
    );

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            pcm_tx_lane #(.DELAYED(DELAYED)) u_tx (
                .clk     (clk),
                .rst     (rst),
                .fs      (fs[ch]),
                .standby (standby[ch]),
                .code    (tx_code[ch]),
                .accept  (arm_v[ch]),
                .drive   (drive_v[ch]),
                .line_bit(bit_v[ch]),
                .err     (sync_err[ch])
            );

            pcm_rx_lane #(.DELAYED(DELAYED), .DLY_W(DLY_W)) u_rx (
                .clk     (clk),
                .rst     (rst),
                .arm     (arm_v[ch]),
                .standby (standby[ch]),
                .delay   (rx_delay),
                .rx_bit  (rx_bit),
                .code_out(rx_code[ch]),
                .valid   (rx_valid[ch])
            );
        end
    endgenerate

    assign tx_oe   = |drive_v;
    assign tx_data = |(drive_v & bit_v);

    // R4
    one_driver_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drive_v));

    // R4
    quiet_line_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_oe |-> !tx_data);

endmodule

// File: tb/pcm_quad_port_tb_top.sv
`timescale 1ns/1ps
module pcm_quad_port_tb_top;

    localparam int FRAME  = 64;
    localparam int NFRAME = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] fs = '0;
    logic [3:0] stby = '0;
    logic [7:0] dly = '0;
    logic [3:0][7:0] txc = '0;
    logic rxd = 1'b0;

    logic tdat_d, toe_d, tdat_n, toe_n;
    logic [3:0][7:0] rxc_d, rxc_n;
    logic [3:0] rv_d, rv_n, er_d, er_n;

    int errors = 0;
    int checks = 0;

    int n_at [4];
    int w_at [4];
    int e_at [4];
    logic [7:0] cf [4];
    logic sb [4];
    int fd;
    logic rxb [FRAME];
    logic [7:0] exp_rx [2][4];

    always #4 clk = ~clk;

    pcm_quad_port #(.NCH(4), .DLY_W(8), .DELAYED(1'b1)) dut_i (
        .clk(clk), .rst(rst), .fs(fs), .standby(stby), .rx_delay(dly),
        .tx_code(txc), .rx_data(rxd), .tx_data(tdat_d), .tx_oe(toe_d),
        .rx_code(rxc_d), .rx_valid(rv_d), .sync_err(er_d)
    );

    pcm_quad_port #(.NCH(4), .DLY_W(8), .DELAYED(1'b0)) dut_nd_i (
        .clk(clk), .rst(rst), .fs(fs), .standby(stby), .rx_delay(dly),
        .tx_code(txc), .rx_data(rxd), .tx_data(tdat_n), .tx_oe(toe_n),
        .rx_code(rxc_n), .rx_valid(rv_n), .sync_err(er_n)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // first period carrying transmit bit 7 (m=0 delayed build, m=1 immediate)
    function automatic int s_of(input int m, input int c);
        return n_at[c] + ((m == 0) ? 1 : 0);
    endfunction

    task automatic check_period(input int p);
        for (int m = 0; m < 2; m++) begin
            logic eoe, ebit;
            logic [3:0] ev, ee;
            logic aoe, abit;
            logic [3:0] av, ae;
            logic [3:0][7:0] ac;
            eoe = 1'b0; ebit = 1'b0; ev = '0; ee = '0;
            for (int c = 0; c < 4; c++) begin
                int s;
                s = s_of(m, c);
                if (n_at[c] >= 0 && !sb[c] && p >= s && p < s + 8) begin
                    eoe  = 1'b1;
                    ebit = cf[c][7 - (p - s)];
                end
                if (e_at[c] >= 0 && p == e_at[c] + 1) ee[c] = 1'b1;
                if (n_at[c] >= 0 && !sb[c] && p == s + fd + 8) begin
                    logic [7:0] v;
                    for (int b = 0; b < 8; b++) v[7 - b] = rxb[s + fd + b];
                    exp_rx[m][c] = v;
                    ev[c] = 1'b1;
                end
            end
            aoe  = (m == 0) ? toe_d  : toe_n;
            abit = (m == 0) ? tdat_d : tdat_n;
            av   = (m == 0) ? rv_d   : rv_n;
            ae   = (m == 0) ? er_d   : er_n;
            ac   = (m == 0) ? rxc_d  : rxc_n;
            // R4 R10: line ownership
            chk(aoe == eoe, "R4 R10", $sformatf("oe m=%0d p=%0d", m, p), aoe, eoe);
            // R2 R3 R5 R11: bit values
            chk(abit == ebit, (m == 0) ? "R2 R5 R11" : "R3 R5 R11",
                $sformatf("data m=%0d p=%0d", m, p), abit, ebit);
            // R7 R10
            chk(av == ev, "R7 R10", $sformatf("valid m=%0d p=%0d", m, p), av, ev);
            // R9
            chk(ae == ee, "R9", $sformatf("err m=%0d p=%0d", m, p), ae, ee);
            // R6 R8 R10
            for (int c = 0; c < 4; c++)
                chk(ac[c] == exp_rx[m][c], "R6 R8 R10",
                    $sformatf("rxcode m=%0d c=%0d p=%0d", m, c, p), ac[c], exp_rx[m][c]);
        end
    endtask

    task automatic plan_frame(input int f);
        int k [5];
        for (int i = 0; i < 5; i++) k[i] = i;
        for (int i = 4; i > 0; i--) begin
            int j, t;
            j = $urandom_range(i, 0);
            t = k[i]; k[i] = k[j]; k[j] = t;
        end
        for (int c = 0; c < 4; c++) begin
            n_at[c] = 8 * k[c] + 1;
            w_at[c] = $urandom_range(3, 1);
            e_at[c] = -1;
            cf[c]   = 8'($urandom);
            sb[c]   = ($urandom_range(3, 0) == 0);
        end
        fd = $urandom_range(15, 0);
        for (int p = 0; p < FRAME; p++) rxb[p] = 1'($urandom);
        case (f)
            0: begin // adjacent slots, zero receive offset (R6 half period)
                for (int c = 0; c < 4; c++) begin
                    n_at[c] = 8 * c + 1; w_at[c] = 1; sb[c] = 1'b0;
                end
                fd = 0;
                cf[0] = 8'h80; cf[1] = 8'h01;
            end
            1: begin // wide pulses (R11), largest offset used
                for (int c = 0; c < 4; c++) begin
                    w_at[c] = 3; sb[c] = 1'b0;
                end
                fd = 15;
            end
            2: begin // R9 collision on channel 0
                for (int c = 0; c < 4; c++) sb[c] = 1'b0;
                w_at[0] = 1;
                e_at[0] = n_at[0] + 3;
            end
            3: begin // R10 standby on two channels
                sb[0] = 1'b0; sb[1] = 1'b1; sb[2] = 1'b1; sb[3] = 1'b0;
            end
            default: ;
        endcase
    endtask

    initial begin
        void'($urandom(32'd7321));
        for (int m = 0; m < 2; m++)
            for (int c = 0; c < 4; c++) exp_rx[m][c] = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #2;
        // R1: reset state
        chk(toe_d == 1'b0 && toe_n == 1'b0, "R1", "oe", {toe_d, toe_n}, 0);
        chk(tdat_d == 1'b0 && tdat_n == 1'b0, "R1", "data", {tdat_d, tdat_n}, 0);
        chk(rv_d == '0 && rv_n == '0, "R1", "valid", {rv_d, rv_n}, 0);
        chk(er_d == '0 && er_n == '0, "R1", "err", {er_d, er_n}, 0);
        chk(rxc_d == '0 && rxc_n == '0, "R1", "rxcode", rxc_d ^ rxc_n, 0);

        for (int f = 0; f < NFRAME; f++) begin
            plan_frame(f);
            for (int p = 0; p < FRAME; p++) begin
                @(posedge clk);
                #1;
                if (p == 0) begin
                    for (int c = 0; c < 4; c++) begin
                        txc[c]  = cf[c];
                        stby[c] = sb[c];
                    end
                    dly = 8'(fd);
                end
                for (int c = 0; c < 4; c++) begin
                    fs[c] = (p >= n_at[c] && p < n_at[c] + w_at[c]) || (p == e_at[c]);
                    // R5: scramble the parallel code once the slot has latched it
                    if (p == n_at[c] + 2) txc[c] = 8'($urandom);
                end
                rxd = rxb[p];
                #2;
                check_period(p);
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule